// File: doc/BRIEF.md
# Saturating Trip Event Counter

This block tallies how many times an alarm has moved from its armed state into its tripped state. It takes the tripped flag from the zone latch and advances a small count once for every new trip. The count stops at five and never wraps. The value appears as a decimal digit on one seven-segment display whose segments are driven active-low.

A dedicated count-clear input sets the tally back to zero. This input is separate from the alarm re-arm. Re-arming the alarm drops the tripped flag but leaves the tally alone.

Detection is edge-based. Holding the tripped flag high for many cycles counts as a single event. The clear input is sampled on the clock, so it acts synchronously. It also serves as the block's reset.

Top module: `trip_tally`

## Requirements
- R1: While `cnt_clr` is high at a clock edge, `trip_count` becomes 0 after that edge. `seg_n` then shows the zero glyph, 7'h40.
- R2: When `trip_in` is sampled high at an edge after being sampled low at the previous edge, `trip_count` rises by one after that same edge, provided it is below 5 and `cnt_clr` is low.
- R3: Holding `trip_in` high over consecutive edges adds nothing beyond the single step taken at its rising edge.
- R4: Once `trip_count` is 5, further rising edges of `trip_in` leave it at 5, and `seg_n` keeps showing 5.
- R5: A fall of `trip_in` (alarm re-arm) leaves `trip_count` and `seg_n` unchanged.
- R6: If `cnt_clr` is high in the same cycle as a rising edge of `trip_in`, the clear wins and the count becomes 0. If `trip_in` then stays high after the clear, no count is taken.
- R7: `seg_n[6:0]` carries segments g..a (bit 0 = a, bit 6 = g), with 0 meaning lit. The codes are 0 -> 7'h40, 1 -> 7'h79, 2 -> 7'h24, 3 -> 7'h30, 4 -> 7'h19, 5 -> 7'h12.
- R8: `trip_count` never exceeds 5 after the first clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| trip_in | input | 1 | Tripped flag from the zone latch, high while tripped |
| cnt_clr | input | 1 | Synchronous count clear, active high, independent of re-arm |
| trip_count | output | 3 | Current saturating trip tally, 0 to 5 |
| seg_n | output | 7 | Active-low segments g..a showing the tally |

## Verification
Two functions can fall on the same edge: the clear, and the increment from a fresh rising edge of `trip_in`. The bench raises `trip_in` and `cnt_clr` together at one edge while the count is non-zero. It expects zero afterwards. It then keeps `trip_in` high after the clear drops and expects the count to stay at zero, because that edge was already consumed. A second case applies the clear while the count sits at saturation, to confirm the clear also overrides the hold at five.

// File: rtl/trip_tally_pkg.sv
package trip_tally_pkg;

    localparam int COUNT_MAX = 5;
    localparam int COUNT_W   = $clog2(COUNT_MAX + 1);
    localparam int SEG_W     = 7;

    typedef logic [COUNT_W-1:0] count_t;
    typedef logic [SEG_W-1:0]   seg_t;

    // per-cycle command for the tally register
    typedef struct packed {
        logic clear;
        logic step;
    } tally_cmd_t;

    // segments lit (active high), bit 0 = a ... bit 6 = g
    function automatic seg_t glyph_lit(input count_t v);
        seg_t s;
        case (v)
            count_t'(0): s = 7'b0111111;
            count_t'(1): s = 7'b0000110;
            count_t'(2): s = 7'b1011011;
            count_t'(3): s = 7'b1001111;
            count_t'(4): s = 7'b1100110;
            count_t'(5): s = 7'b1101101;
            default:     s = 7'b1000000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/trip_edge.sv
module trip_edge (
    input  logic clk,
    input  logic trip_in,
    output logic rise
);
    logic trip_q;

    // history always follows the input, so a clear leaves no stale edge behind
    always_ff @(posedge clk) begin
        trip_q <= trip_in;
    end

    assign rise = trip_in & ~trip_q;
endmodule

// File: rtl/sat_tally.sv
module sat_tally
    import trip_tally_pkg::*;
#(
    parameter int MAX_VAL = COUNT_MAX
) (
    input  logic       clk,
    input  tally_cmd_t cmd,
    output count_t     value
);
    localparam count_t TOP = count_t'(MAX_VAL);

    count_t value_q;

    always_ff @(posedge clk) begin
        if (cmd.clear) begin
            value_q <= '0;
        end else if (cmd.step && (value_q != TOP)) begin
            value_q <= value_q + count_t'(1);
        end
    end

    assign value = value_q;
endmodule

// File: rtl/seg_drive.sv
module seg_drive
    import trip_tally_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  count_t value,
    output seg_t   seg
);
    seg_t lit;

    always_comb begin
        lit = glyph_lit(value);
    end

    for (genvar i = 0; i < SEG_W; i++) begin : g_seg
        if (ACTIVE_LOW) begin : g_low
            assign seg[i] = ~lit[i];
        end else begin : g_high
            assign seg[i] = lit[i];
        end
    end
endmodule

// File: rtl/trip_tally.sv
module trip_tally
    import trip_tally_pkg::*;
(
    input  logic                clk,
    input  logic                trip_in,
    input  logic                cnt_clr,
    output logic [COUNT_W-1:0]  trip_count,
    output logic [SEG_W-1:0]    seg_n
);
    logic       rise;
    tally_cmd_t cmd;
    count_t     tally;

    trip_edge u_edge (
        .clk     (clk),
        .trip_in (trip_in),
        .rise    (rise)
    );

    always_comb begin
        cmd.clear = cnt_clr;
        cmd.step  = rise;
    end

    sat_tally #(.MAX_VAL(COUNT_MAX)) u_tally (
        .clk   (clk),
        .cmd   (cmd),
        .value (tally)
    );

    seg_drive #(.ACTIVE_LOW(1'b1)) u_seg (
        .value (tally),
        .seg   (seg_n)
    );

    assign trip_count = tally;
endmodule

// File: rtl/trip_tally_chk.sv
module trip_tally_chk
    import trip_tally_pkg::*;
(
    input logic                clk,
    input logic                trip_in,
    input logic                cnt_clr,
    input logic [COUNT_W-1:0]  trip_count
);
    logic live = 1'b0;

    always_ff @(posedge clk) begin
        if (cnt_clr) live <= 1'b1;
    end

    // R1: a clear empties the tally
    p_clear_zero_r1: assert property (@(posedge clk)
        cnt_clr |=> (trip_count == '0));

    // R2: a fresh trip below the ceiling adds one
    p_step_on_rise_r2: assert property (@(posedge clk) disable iff (cnt_clr || !live)
        ($rose(trip_in) && (trip_count != count_t'(COUNT_MAX)))
        |=> (trip_count == $past(trip_count) + count_t'(1)));

    // R3 / R5: without a rising edge the tally holds
    p_hold_no_rise_r3: assert property (@(posedge clk) disable iff (cnt_clr || !live)
        !$rose(trip_in) |=> $stable(trip_count));

    // R4: the ceiling is sticky
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (cnt_clr || !live)
        (trip_count == count_t'(COUNT_MAX)) |=> (trip_count == count_t'(COUNT_MAX)));

    // R8: never above the ceiling
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!live)
        trip_count <= count_t'(COUNT_MAX));
endmodule

bind trip_tally trip_tally_chk u_chk (
    .clk        (clk),
    .trip_in    (trip_in),
    .cnt_clr    (cnt_clr),
    .trip_count (trip_count)
);

// File: tb/trip_tally_test.sv
module trip_tally_test;
    logic       clk = 1'b0;
    logic       trip_in = 1'b0;
    logic       cnt_clr = 1'b0;
    logic [2:0] trip_count;
    logic [6:0] seg_n;

    int vectors = 0;
    int fails   = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    trip_tally uut (
        .clk        (clk),
        .trip_in    (trip_in),
        .cnt_clr    (cnt_clr),
        .trip_count (trip_count),
        .seg_n      (seg_n)
    );

    // R7: expected active-low glyphs, g..a
    function automatic logic [6:0] want_seg(input int v);
        case (v)
            0: return 7'h40;
            1: return 7'h79;
            2: return 7'h24;
            3: return 7'h30;
            4: return 7'h19;
            5: return 7'h12;
            default: return 7'h7f;
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_out(input string tag);
        check({tag, " count"}, int'(trip_count), exp_cnt);
        check({tag, " seg R7"}, int'(seg_n), int'(want_seg(exp_cnt)));
    endtask

    // drive at the falling edge, look just after the next rising edge
    task automatic step(input logic t, input logic c);
        @(negedge clk);
        trip_in = t;
        cnt_clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic t_clear_r1();
        step(1'b0, 1'b1);
        exp_cnt = 0;
        check_out("R1 clear");
        step(1'b0, 1'b0);
        check_out("R1 idle");
    endtask

    task automatic t_trip_rearm_r2_r5();
        step(1'b1, 1'b0);
        exp_cnt = 1;
        check_out("R2 first trip");
        step(1'b0, 1'b0);
        check_out("R5 rearm");
        step(1'b0, 1'b0);
        check_out("R5 idle");
    endtask

    task automatic t_hold_level_r3();
        step(1'b1, 1'b0);
        exp_cnt = exp_cnt + 1;
        check_out("R2 second trip");
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b0);
            check_out("R3 level held");
        end
        step(1'b0, 1'b0);
        check_out("R5 rearm after hold");
    endtask

    task automatic t_saturate_r4();
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0);
            if (exp_cnt < 5) exp_cnt = exp_cnt + 1;
            check_out("R4 trip toward ceiling");
            step(1'b0, 1'b0);
            check_out("R5 rearm toward ceiling");
        end
        check("R4 ceiling reached", int'(trip_count), 5);
        step(1'b1, 1'b0);
        check_out("R4 trip past ceiling");
        step(1'b0, 1'b0);
        check_out("R4 rearm at ceiling");
    endtask

    task automatic t_clear_vs_edge_r6();
        // clear applied at the ceiling
        step(1'b0, 1'b1);
        exp_cnt = 0;
        check_out("R6 clear from ceiling");
        step(1'b1, 1'b0);
        exp_cnt = 1;
        check_out("R6 trip after clear");
        step(1'b0, 1'b0);
        check_out("R6 rearm");
        // rising edge and clear on the same edge
        step(1'b1, 1'b1);
        exp_cnt = 0;
        check_out("R6 clear beats edge");
        step(1'b1, 1'b0);
        check_out("R6 edge consumed");
        step(1'b1, 1'b0);
        check_out("R6 level after clear");
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        exp_cnt = 1;
        check_out("R6 new trip counts");
    endtask

    task automatic t_glyphs_r7();
        step(1'b0, 1'b1);
        exp_cnt = 0;
        check_out("R7 glyph 0");
        for (int v = 1; v <= 5; v++) begin
            step(1'b0, 1'b0);
            step(1'b1, 1'b0);
            exp_cnt = v;
            check_out("R7 glyph walk");
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        t_clear_r1();
        t_trip_rearm_r2_r5();
        t_hold_level_r3();
        t_saturate_r4();
        t_clear_vs_edge_r6();
        t_glyphs_r7();
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule